// File: doc/BRIEF.md
# Five-Wire SPI Packet Master

This block is the bus-master end of a serial link that runs over five wires: a serial clock, a master-out data line, a master-in data line, an active-low select, and an active-low request line that the far side pulls low when it has a packet for the master. No wire tells the master that the far side is ready. The master therefore opens every transaction on the chance that the peer is listening. It then judges the first byte that comes back on the master-in line: a zero byte accepts the transaction, and any other value rejects it.

To send a packet, the master first runs a two-byte transaction that carries the packet length, high byte first. It then runs one transaction per frame of up to MTU payload bytes. Payload bytes are fetched by index from the user side, so a frame that was refused can be replayed without any buffering. To receive a packet, the master waits for the request line. It sends a two-byte zero header, then reads a guard byte followed by the two length bytes, and then reads frames that each hold a guard byte and up to MTU-1 payload bytes. A refused transaction is cut short after its first byte, and the same transaction is retried after a programmable idle time. If the refusals go past a set limit, the packet is dropped with an error pulse.

Top module: `spi5w_master`

## Requirements
- R1: After reset, cs_n is high, sclk is low, and busy, done and err are low. cs_n stays high whenever busy is low.
- R2: The link runs in SPI mode 0 with the most significant bit first. sclk idles low, the master-in line is sampled on the rising edge, and mosi changes only while sclk is low.
- R3: A write runs a 2-byte header transaction carrying wr_len (byte 0 = bits 15:8, byte 1 = bits 7:0). It then runs payload transactions of MTU bytes each, taken from wr_data at wr_addr = 0, 1, 2 …, and the last transaction carries the remainder.
- R4: When the first byte received in a transaction is not 0x00, cs_n rises right after that byte, and the same transaction is restarted.
- R5: After a refused transaction, cs_n stays high for at least cfg_backoff clock cycles before it falls again.
- R6: A read starts only while req_n is low. It begins with a 2-byte transaction in which mosi sends 0x00 twice.
- R7: The second read transaction is 3 bytes long: a guard byte, then the length high byte, then the length low byte. rd_len shows the length from then on.
- R8: Each read payload transaction is a guard byte followed by up to MTU-1 data bytes. Each data byte appears once on rd_data, with its packet index on rd_addr, during a one-cycle rd_valid pulse.
- R9: done pulses for one cycle once a whole packet has been sent or received. busy is high from the accepted start until then.
- R10: When one transaction is refused more than cfg_max_retry times in a row, err pulses for one cycle, the packet is dropped without a done pulse, and the master returns to idle after cfg_max_retry+1 attempts.
- R11: A write of length 0 consists of the header transaction only, followed by done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_start | input | 1 | Start a packet write when idle |
| wr_len | input | 16 | Length in bytes of the packet to write |
| wr_addr | output | 16 | Index of the payload byte being fetched |
| wr_data | input | 8 | Payload byte at wr_addr |
| rd_valid | output | 1 | One-cycle strobe for a received payload byte |
| rd_addr | output | 16 | Index of the received byte |
| rd_data | output | 8 | Received payload byte |
| rd_len | output | 16 | Length of the packet being read |
| cfg_backoff | input | 16 | Idle cycles between a refusal and the retry |
| cfg_max_retry | input | 8 | Retries allowed per transaction |
| req_n | input | 1 | Active-low read request from the peer |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Master-out serial data |
| miso | input | 1 | Master-in serial data |
| cs_n | output | 1 | Active-low select |
| busy | output | 1 | Packet in progress |
| done | output | 1 | Packet completed pulse |
| err | output | 1 | Retry limit exceeded pulse |

## Verification
Writes are run with a length that splits into one full frame plus a shorter one, with a length that leaves a remainder after refusals, and with length zero. Comparing the transaction lengths and the bytes seen by a mode-0 peer model separates correct frame splitting from off-by-one or byte-order faults. Reads are run against a peer that is always ready and against one that refuses the length transaction and a payload frame, which shows whether guard bytes are being mistaken for data. A peer that never answers checks the attempt count and the error path, and a quiet request line checks that no read starts on its own.

// File: rtl/spi5w_pkg.sv
`timescale 1ns/1ps
package spi5w_pkg;
  typedef enum logic [2:0] {
    K_WHDR, K_WDAT, K_RZERO, K_RLEN, K_RDAT
  } xfer_kind_t;

  typedef enum logic [1:0] {
    S_IDLE, S_WAIT, S_XFER
  } seq_state_t;
endpackage

// File: rtl/spi5w_byte_io.sv
`timescale 1ns/1ps
// Mode-0 byte shifter: one byte per start pulse, MSB first.
module spi5w_byte_io #(
  parameter int CLK_DIV = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic [7:0] tx_byte,
  input  logic       miso,
  output logic       sclk,
  output logic       mosi,
  output logic       done,
  output logic [7:0] rx_byte
);
  localparam int CW = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;
  localparam logic [CW-1:0] HALF_END = CW'(CLK_DIV - 1);

  logic          busy_q, busy_d;
  logic          sclk_q, sclk_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [2:0]    bit_q, bit_d;
  logic [7:0]    tx_q, tx_d;
  logic [7:0]    rx_q, rx_d;
  logic          done_q, done_d;

  always_comb begin
    busy_d = busy_q;
    sclk_d = sclk_q;
    cnt_d  = cnt_q;
    bit_d  = bit_q;
    tx_d   = tx_q;
    rx_d   = rx_q;
    done_d = 1'b0;
    if (start && !busy_q) begin
      busy_d = 1'b1;
      sclk_d = 1'b0;
      cnt_d  = '0;
      bit_d  = '0;
      tx_d   = tx_byte;
    end else if (busy_q) begin
      if (cnt_q == HALF_END) begin
        cnt_d = '0;
        if (!sclk_q) begin
          sclk_d = 1'b1;
          rx_d   = {rx_q[6:0], miso};
        end else begin
          sclk_d = 1'b0;
          if (bit_q == 3'd7) begin
            busy_d = 1'b0;
            done_d = 1'b1;
          end else begin
            bit_d = bit_q + 3'd1;
            tx_d  = {tx_q[6:0], 1'b0};
          end
        end
      end else begin
        cnt_d = cnt_q + CW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      sclk_q <= 1'b0;
      cnt_q  <= '0;
      bit_q  <= '0;
      tx_q   <= '0;
      rx_q   <= '0;
      done_q <= 1'b0;
    end else begin
      busy_q <= busy_d;
      sclk_q <= sclk_d;
      cnt_q  <= cnt_d;
      bit_q  <= bit_d;
      tx_q   <= tx_d;
      rx_q   <= rx_d;
      done_q <= done_d;
    end
  end

  assign sclk    = sclk_q;
  assign mosi    = tx_q[7];
  assign done    = done_q;
  assign rx_byte = rx_q;
endmodule

// File: rtl/spi5w_seq.sv
`timescale 1ns/1ps
// Transaction and packet sequencer: guard check, retry, framing.
module spi5w_seq
  import spi5w_pkg::*;
#(
  parameter int MTU     = 4,
  parameter int CLK_DIV = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_start,
  input  logic [15:0] wr_len,
  input  logic [7:0]  wr_data,
  input  logic        req_n,
  input  logic [15:0] cfg_backoff,
  input  logic [7:0]  cfg_max_retry,
  input  logic        byte_done,
  input  logic [7:0]  rx_byte,
  output logic        byte_start,
  output logic [7:0]  tx_byte,
  output logic        cs_n,
  output logic [15:0] wr_addr,
  output logic        rd_valid,
  output logic [15:0] rd_addr,
  output logic [7:0]  rd_data,
  output logic [15:0] rd_len,
  output logic        busy,
  output logic        done,
  output logic        err
);
  localparam logic [15:0] WFR = 16'(MTU);
  localparam logic [15:0] RFR = 16'(MTU - 1);
  localparam logic [15:0] GAP = 16'(CLK_DIV);

  function automatic logic [15:0] cap(input logic [15:0] v, input logic [15:0] m);
    return (v > m) ? m : v;
  endfunction

  seq_state_t  st_q, st_d;
  xfer_kind_t  kind_q, kind_d;
  logic [15:0] tlen_q, tlen_d, bidx_q, bidx_d, pos_q, pos_d, plen_q, plen_d;
  logic [15:0] cnt_q, cnt_d, lim_q, lim_d, npos, nlen;
  logic [7:0]  retry_q, retry_d;
  logic        fin_q, fin_d, cs_q, cs_d, start_q, start_d;
  logic        rv_q, rv_d, done_q, done_d, err_q, err_d;
  logic [15:0] ra_q, ra_d;
  logic [7:0]  rdat_q, rdat_d;

  always_comb begin
    st_d = st_q;   kind_d = kind_q; tlen_d = tlen_q; bidx_d = bidx_q;
    pos_d = pos_q; plen_d = plen_q; cnt_d = cnt_q;   lim_d = lim_q;
    retry_d = retry_q; fin_d = fin_q; cs_d = cs_q;
    ra_d = ra_q; rdat_d = rdat_q;
    start_d = 1'b0; rv_d = 1'b0; done_d = 1'b0; err_d = 1'b0;
    npos = '0; nlen = '0;
    case (st_q)
      S_IDLE: begin
        if (wr_start || !req_n) begin
          kind_d  = wr_start ? K_WHDR : K_RZERO;
          plen_d  = wr_start ? wr_len : 16'd0;
          tlen_d  = 16'd2;
          pos_d   = '0;
          retry_d = '0;
          fin_d   = 1'b0;
          cnt_d   = '0;
          lim_d   = '0;
          st_d    = S_WAIT;
        end
      end
      S_WAIT: begin
        if (cnt_q >= lim_q) begin
          if (fin_q) begin
            done_d = 1'b1;
            st_d   = S_IDLE;
          end else begin
            cs_d    = 1'b0;
            bidx_d  = '0;
            start_d = 1'b1;
            st_d    = S_XFER;
          end
        end else begin
          cnt_d = cnt_q + 16'd1;
        end
      end
      default: begin
        if (byte_done) begin
          if (bidx_q == 16'd0 && rx_byte != 8'h00) begin
            cs_d  = 1'b1;
            cnt_d = '0;
            if (retry_q >= cfg_max_retry) begin
              err_d = 1'b1;
              st_d  = S_IDLE;
            end else begin
              retry_d = retry_q + 8'd1;
              lim_d   = cfg_backoff;
              st_d    = S_WAIT;
            end
          end else begin
            if (kind_q == K_RLEN && bidx_q == 16'd1) plen_d[15:8] = rx_byte;
            if (kind_q == K_RLEN && bidx_q == 16'd2) plen_d[7:0]  = rx_byte;
            if (kind_q == K_RDAT && bidx_q != 16'd0) begin
              rv_d   = 1'b1;
              ra_d   = pos_q + bidx_q - 16'd1;
              rdat_d = rx_byte;
            end
            if (bidx_q == tlen_q - 16'd1) begin
              cs_d    = 1'b1;
              retry_d = '0;
              cnt_d   = '0;
              lim_d   = GAP;
              st_d    = S_WAIT;
              case (kind_q)
                K_WHDR: begin
                  if (plen_q == 16'd0) fin_d = 1'b1;
                  else begin
                    kind_d = K_WDAT;
                    tlen_d = cap(plen_q, WFR);
                  end
                end
                K_WDAT: begin
                  npos  = pos_q + tlen_q;
                  pos_d = npos;
                  if (npos >= plen_q) fin_d = 1'b1;
                  else tlen_d = cap(plen_q - npos, WFR);
                end
                K_RZERO: begin
                  kind_d = K_RLEN;
                  tlen_d = 16'd3;
                end
                K_RLEN: begin
                  nlen = {plen_q[15:8], rx_byte};
                  if (nlen == 16'd0) fin_d = 1'b1;
                  else begin
                    kind_d = K_RDAT;
                    pos_d  = '0;
                    tlen_d = cap(nlen, RFR) + 16'd1;
                  end
                end
                default: begin
                  npos  = pos_q + tlen_q - 16'd1;
                  pos_d = npos;
                  if (npos >= plen_q) fin_d = 1'b1;
                  else tlen_d = cap(plen_q - npos, RFR) + 16'd1;
                end
              endcase
            end else begin
              bidx_d  = bidx_q + 16'd1;
              start_d = 1'b1;
            end
          end
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= S_IDLE; kind_q <= K_WHDR; tlen_q <= '0; bidx_q <= '0;
      pos_q <= '0; plen_q <= '0; cnt_q <= '0; lim_q <= '0;
      retry_q <= '0; fin_q <= 1'b0; cs_q <= 1'b1; start_q <= 1'b0;
      rv_q <= 1'b0; ra_q <= '0; rdat_q <= '0; done_q <= 1'b0; err_q <= 1'b0;
    end else begin
      st_q <= st_d; kind_q <= kind_d; tlen_q <= tlen_d; bidx_q <= bidx_d;
      pos_q <= pos_d; plen_q <= plen_d; cnt_q <= cnt_d; lim_q <= lim_d;
      retry_q <= retry_d; fin_q <= fin_d; cs_q <= cs_d; start_q <= start_d;
      rv_q <= rv_d; ra_q <= ra_d; rdat_q <= rdat_d; done_q <= done_d; err_q <= err_d;
    end
  end

  always_comb begin
    case (kind_q)
      K_WHDR:  tx_byte = bidx_q[0] ? plen_q[7:0] : plen_q[15:8];
      K_WDAT:  tx_byte = wr_data;
      default: tx_byte = 8'h00;
    endcase
  end

  assign wr_addr    = pos_q + bidx_q;
  assign byte_start = start_q;
  assign cs_n       = cs_q;
  assign rd_valid   = rv_q;
  assign rd_addr    = ra_q;
  assign rd_data    = rdat_q;
  assign rd_len     = plen_q;
  assign busy       = (st_q != S_IDLE);
  assign done       = done_q;
  assign err        = err_q;
endmodule

// File: rtl/spi5w_master.sv
`timescale 1ns/1ps
module spi5w_master #(
  parameter int MTU     = 4,
  parameter int CLK_DIV = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_start,
  input  logic [15:0] wr_len,
  output logic [15:0] wr_addr,
  input  logic [7:0]  wr_data,
  output logic        rd_valid,
  output logic [15:0] rd_addr,
  output logic [7:0]  rd_data,
  output logic [15:0] rd_len,
  input  logic [15:0] cfg_backoff,
  input  logic [7:0]  cfg_max_retry,
  input  logic        req_n,
  output logic        sclk,
  output logic        mosi,
  input  logic        miso,
  output logic        cs_n,
  output logic        busy,
  output logic        done,
  output logic        err
);
  localparam int SYNC_STAGES = 2;

  logic [SYNC_STAGES-1:0] rst_pipe, req_pipe;
  logic       rst_i, req_s;
  logic       b_start, b_done;
  logic [7:0] b_tx, b_rx;

  // Reset asserts at once and releases on a clock edge.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[SYNC_STAGES-2:0], 1'b1};
  end
  assign rst_i = rst_pipe[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) req_pipe <= '1;
    else        req_pipe <= {req_pipe[SYNC_STAGES-2:0], req_n};
  end
  assign req_s = req_pipe[SYNC_STAGES-1];

  spi5w_seq #(.MTU(MTU), .CLK_DIV(CLK_DIV)) u_seq (
    .clk(clk), .rst_n(rst_i), .wr_start(wr_start), .wr_len(wr_len),
    .wr_data(wr_data), .req_n(req_s), .cfg_backoff(cfg_backoff),
    .cfg_max_retry(cfg_max_retry), .byte_done(b_done), .rx_byte(b_rx),
    .byte_start(b_start), .tx_byte(b_tx), .cs_n(cs_n), .wr_addr(wr_addr),
    .rd_valid(rd_valid), .rd_addr(rd_addr), .rd_data(rd_data),
    .rd_len(rd_len), .busy(busy), .done(done), .err(err)
  );

  spi5w_byte_io #(.CLK_DIV(CLK_DIV)) u_io (
    .clk(clk), .rst_n(rst_i), .start(b_start), .tx_byte(b_tx),
    .miso(miso), .sclk(sclk), .mosi(mosi), .done(b_done), .rx_byte(b_rx)
  );
endmodule

// File: rtl/spi5w_master_chk.sv
`timescale 1ns/1ps
module spi5w_master_chk (
  input logic clk,
  input logic rst_n,
  input logic cs_n,
  input logic sclk,
  input logic mosi,
  input logic busy,
  input logic done,
  input logic err,
  input logic rd_valid
);
  // R1
  idle_select_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> cs_n);
  // R2
  sclk_parked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> !sclk);
  // R2
  mosi_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n && sclk && $past(sclk)) |-> $stable(mosi));
  // R9
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R10
  done_err_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && err));
  // R8
  rd_strobe_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> busy);
endmodule

bind spi5w_master spi5w_master_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .mosi(mosi),
  .busy(busy), .done(done), .err(err), .rd_valid(rd_valid)
);

// File: tb/sim_spi5w_master.sv
`timescale 1ns/1ps
module sim_spi5w_master;
  localparam int MTU = 4;
  localparam int DIV = 2;

  logic clk = 1'b0, rst_n = 1'b0, wr_start = 1'b0;
  logic [15:0] wr_len = '0, wr_addr, rd_addr, rd_len;
  logic [15:0] cfg_backoff = 16'd10;
  logic [7:0]  cfg_max_retry = 8'd3, wr_data, rd_data;
  logic rd_valid, sclk, mosi, cs_n, busy, done, err;
  logic miso_r = 1'b1, req_r = 1'b1;

  logic [7:0] wmem [0:63];
  logic [7:0] rmem [0:63];
  logic [7:0] spkt [0:63];
  assign wr_data = wmem[wr_addr[5:0]];

  spi5w_master #(.MTU(MTU), .CLK_DIV(DIV)) u0 (
    .clk(clk), .rst_n(rst_n), .wr_start(wr_start), .wr_len(wr_len),
    .wr_addr(wr_addr), .wr_data(wr_data), .rd_valid(rd_valid),
    .rd_addr(rd_addr), .rd_data(rd_data), .rd_len(rd_len),
    .cfg_backoff(cfg_backoff), .cfg_max_retry(cfg_max_retry),
    .req_n(req_r), .sclk(sclk), .mosi(mosi), .miso(miso_r),
    .cs_n(cs_n), .busy(busy), .done(done), .err(err)
  );

  always #4 clk = ~clk;

  int checks = 0, errors = 0;
  int n_done = 0, n_err = 0, n_rv = 0;

  // Peer model (mode 0)
  logic [63:0] s_busy_mask = '0;
  bit   s_read = 0, s_on = 0, cur_rdy = 0;
  int   s_stage = 0, s_dptr = 0, tr = 0, byte_i = 0, bp = 0;
  logic [15:0] s_len = '0;
  logic [7:0]  cur = '0, msh = '0;
  time  t_rise = 0;
  int   tl_len [0:63];
  bit   tl_rdy [0:63];
  int   tl_gap [0:63];
  logic [7:0] tl_b [0:63][0:7];

  function automatic logic [7:0] resp(int i);
    if (!cur_rdy) return 8'hFF;
    if (!s_read || i == 0 || s_stage == 0) return 8'h00;
    if (s_stage == 1) return (i == 1) ? s_len[15:8] : s_len[7:0];
    return spkt[(s_dptr + i - 1) & 63];
  endfunction

  always @(negedge cs_n) if (s_on && tr < 64) begin
    cur_rdy = !s_busy_mask[tr];
    byte_i = 0; bp = 0;
    cur = resp(0);
    miso_r = cur[7];
    tl_gap[tr] = int'(($time - t_rise) / 8);
  end

  always @(posedge sclk) if (s_on && !cs_n) begin
    msh = {msh[6:0], mosi};
    if (bp == 7) begin
      if (byte_i < 8 && tr < 64) tl_b[tr][byte_i] = msh;
      byte_i++;
      cur = resp(byte_i);
      bp = 0;
    end else bp++;
  end

  always @(negedge sclk) if (s_on && !cs_n) miso_r = cur[7-bp];

  always @(posedge cs_n) if (s_on && tr < 64) begin
    t_rise = $time;
    tl_len[tr] = byte_i;
    tl_rdy[tr] = cur_rdy;
    if (cur_rdy && s_read) begin
      if (s_stage == 0) begin req_r = 1'b1; s_stage = 1; end
      else if (s_stage == 1) s_stage = 2;
      else s_dptr += byte_i - 1;
    end
    tr++;
  end

  always @(negedge clk) begin
    if (done) n_done++;
    if (err) n_err++;
    if (rd_valid) begin rmem[rd_addr[5:0]] = rd_data; n_rv++; end
  end

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic prep(bit rd, int len, logic [63:0] mask);
    @(negedge clk);
    s_read = rd; s_stage = 0; s_dptr = 0; tr = 0; s_len = 16'(len);
    s_busy_mask = mask; n_done = 0; n_err = 0; n_rv = 0;
    for (int i = 0; i < 64; i++) begin
      wmem[i] = 8'(8'h30 + i * 7); spkt[i] = 8'(8'hA1 + i * 13); rmem[i] = 8'h00;
    end
    t_rise = $time;
  endtask

  task automatic wait_end();
    int n = 0;
    while (n_done + n_err == 0 && n < 20000) begin @(negedge clk); n++; end
    repeat (4) @(negedge clk);
  endtask

  function automatic int mn(int a, int b); return (a < b) ? a : b; endfunction

  function automatic int lg_len(bit rd, int plen, int k);
    if (k == 0) return 2;
    if (!rd) return mn(MTU, plen - (k-1)*MTU);
    if (k == 1) return 3;
    return 1 + mn(MTU-1, plen - (k-2)*(MTU-1));
  endfunction

  function automatic int lg_byte(bit rd, int plen, int k, int j);
    if (rd) return 0;
    if (k == 0) return (j == 0) ? (plen >> 8) : (plen & 255);
    return int'(wmem[(k-1)*MTU + j]);
  endfunction

  // Walks the peer log against the expected transaction list.
  task automatic verify(bit rd, int plen, string tag);
    int k = 0, mism;
    int nlog = rd ? 2 + (plen + MTU - 2) / (MTU - 1) : 1 + (plen + MTU - 1) / MTU;
    for (int e = 0; e < tr; e++) begin
      if (e > 0 && !tl_rdy[e-1])
        chk("R5 backoff gap", int'(tl_gap[e] >= int'(cfg_backoff)), 1);
      if (!tl_rdy[e]) chk("R4 abort after first byte", tl_len[e], 1);
      else begin
        chk({tag, " transaction length"}, tl_len[e], lg_len(rd, plen, k));
        mism = 0;
        for (int j = 0; j < mn(tl_len[e], 8); j++)
          if (int'(tl_b[e][j]) != lg_byte(rd, plen, k, j)) mism++;
        chk({tag, " R2 mosi bytes"}, mism, 0);
        k++;
      end
    end
    chk({tag, " completed transactions"}, k, nlog);
    chk("R9 done pulses", n_done, 1);
    chk("R10 no err", n_err, 0);
    chk("R9 busy clear", int'(busy), 0);
  endtask

  task automatic start_write(int len);
    @(negedge clk); wr_len = 16'(len); wr_start = 1'b1;
    @(negedge clk); wr_start = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 cs_n", int'(cs_n), 1);
    chk("R1 sclk", int'(sclk), 0);
    chk("R1 busy", int'(busy), 0);
    chk("R1 done", int'(done), 0);
    chk("R1 err", int'(err), 0);
  endtask

  task automatic t_write_plain();   // R3
    prep(0, 6, '0); start_write(6); wait_end();
    verify(0, 6, "R3");
    chk("R3 transactions", tr, 3);
  endtask

  task automatic t_write_refused(); // R4 R5
    prep(0, 5, 64'b1010); start_write(5); wait_end();
    verify(0, 5, "R4");
    chk("R4 attempts", tr, 5);
  endtask

  task automatic t_write_empty();   // R11
    prep(0, 0, '0); start_write(0); wait_end();
    verify(0, 0, "R11");
    chk("R11 only header", tr, 1);
  endtask

  task automatic t_read_plain();    // R6 R7 R8
    int mism = 0;
    prep(1, 7, '0);
    repeat (200) @(negedge clk);
    chk("R6 no read without request", tr, 0);
    chk("R6 idle without request", int'(busy), 0);
    req_r = 1'b0;
    wait_end();
    verify(1, 7, "R6");
    chk("R7 rd_len", int'(rd_len), 7);
    chk("R8 strobes", n_rv, 7);
    for (int i = 0; i < 7; i++) if (rmem[i] != spkt[i]) mism++;
    chk("R8 data", mism, 0);
  endtask

  task automatic t_read_refused();  // R4 R8
    int mism = 0;
    prep(1, 3, 64'b1010);
    req_r = 1'b0;
    wait_end();
    verify(1, 3, "R8");
    chk("R8 strobes after retries", n_rv, 3);
    for (int i = 0; i < 3; i++) if (rmem[i] != spkt[i]) mism++;
    chk("R8 data after retries", mism, 0);
  endtask

  task automatic t_give_up();       // R10
    int ab = 0;
    cfg_max_retry = 8'd2;
    prep(0, 4, '1); start_write(4); wait_end();
    for (int e = 0; e < tr; e++) if (tl_len[e] == 1) ab++;
    chk("R10 attempts", tr, 3);
    chk("R10 all cut short", ab, 3);
    chk("R10 err pulses", n_err, 1);
    chk("R10 no done", n_done, 0);
    chk("R10 idle", int'(busy), 0);
    chk("R10 cs_n released", int'(cs_n), 1);
    cfg_max_retry = 8'd3;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    s_on = 1;
    t_reset();
    t_write_plain();
    t_write_refused();
    t_write_empty();
    t_read_plain();
    t_read_refused();
    t_give_up();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule